// File: doc/BRIEF.md
# Raster timing generator

This block produces the horizontal and vertical timing for one raster video stream. It runs on a single pixel clock. A pixel counter and a line counter sweep the frame, and six timing outputs are decoded from them: horizontal sync, vertical sync, horizontal blank, vertical blank, active video and active chroma. Every edge position and every output polarity comes from a small word-addressed register port. Vertical blank and vertical sync change state at a programmable pixel inside their boundary line rather than only at the first pixel.

Software writes new timing into shadow registers, then requests a commit. The block copies the whole shadow set into the working set at the next frame boundary, or on the next clock if the generator is stopped. A frame never mixes old and new settings. Two sticky event flags mark the start of a frame and the start of vertical blank. Each flag can be routed to a level interrupt output. The other control bits are stored and read back and have no effect on timing.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset all six timing outputs are 1. This is the inactive level for the reset polarity of 0. irq_o is 0, and the control (0x000) and status (0x004) registers read 0.
- R2: The timing registers sit at 0x60 + offset and read back their shadow value. The offsets are: 0x00 active size (lines 28:16, pixels 12:0), 0x0C polarity (bits 5:0), 0x10 total pixels per line (12:0), 0x14 total lines (12:0), 0x18 hsync (end 28:16, start 12:0), 0x1C vblank pixel offsets (end 28:16, start 12:0), 0x20 vsync lines (end 28:16, start 12:0) and 0x24 vsync pixel offsets (end 28:16, start 12:0). Bits outside these fields read 0, and 0x64/0x68 read 0.
- R3: While enabled, the pixel count h runs from 0 to total pixels minus 1 and then wraps. The line count v advances on each wrap and returns to 0 after total lines minus 1. Each output shows the decode of the (v,h) position of the previous clock.
- R4: Hblank is true when h ≥ active pixels. Active video and active chroma are true when neither hblank nor vblank is true.
- R5: Hsync is true when hsync start ≤ h < hsync end.
- R6: Positions compare in raster order (v first, then h). Vblank is true from (active lines, vblank start offset) to the end of the frame. It is also true on line 0 before pixel (vblank end offset). Vsync is true from (vsync start line, vsync start offset) up to, but not including, (vsync end line, vsync end offset).
- R7: Polarity bits are vblank=0, hblank=1, vsync=2, hsync=3, active video=4 and active chroma=5. A 1 drives that output high when the signal is true. A 0 drives it low when true.
- R8: Control bit 2 enables the generator. While it is 0 the counters stay at (0,0) and every output sits at its inactive level. Enabling starts the count from (0,0).
- R9: Timing register writes change nothing until control bit 0 is written as 1. The copy to the working set then happens on the clock edge where the count leaves the last pixel of the frame, or on the next edge if the generator is stopped. Control bit 0 reads 1 while the commit is pending.
- R10: Status bit 13 is set when a frame starts (position (0,0) while enabled). Status bit 12 is set at the position where vblank begins. Both are sticky and are cleared by writing 1 to them. If an event and its clear occur in the same cycle, the event wins.
- R11: irq_o is 1 exactly when a status bit is set and the same bit is set in the interrupt-enable register (0x00C, bits 13 and 12).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| active_video_o | output | 1 | Active video |
| active_chroma_o | output | 1 | Active chroma |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a commit issued in the middle of a running frame. The new settings must stay invisible until the last pixel of the frame, and then take effect together. The bench reaches this case by reprogramming random timings while the generator runs, leaving the shadow values uncommitted for a while, and then committing with the enable still set. A reference model follows every cycle and checks that the old timing holds up to the frame boundary.

The random configurations place the vblank and vsync pixel offsets anywhere in the line. This exercises the raster-order comparisons at both ends of each window.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int PW       = 13,
  parameter int AW       = 9,
  parameter int NREG     = 10,
  parameter int GEN_BASE = 'h60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          active_video_o,
  output logic          active_chroma_o,
  output logic          irq_o
);
  localparam int HI = 16;
  localparam int EV = 12;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'('hC);
  localparam logic [AW-1:0] A_GEN  = AW'(GEN_BASE);
  localparam logic [31:0] FLD  = {{(32-PW){1'b0}}, {PW{1'b1}}};
  localparam logic [31:0] DUAL = (FLD << HI) | FLD;

  function automatic logic [31:0] wmask(input int i);
    case (i)
      0, 6, 7, 8, 9: return DUAL;
      3:             return 32'h3F;
      4, 5:          return FLD;
      default:       return '0;
    endcase
  endfunction

  function automatic logic at_or_after(input logic [PW-1:0] v, h, lv, lh);
    return (v > lv) || (v == lv && h >= lh);
  endfunction

  logic [31:0]   shd [NREG];
  logic [31:0]   wrk [NREG];
  logic [31:0]   ctrl;
  logic          pend;
  logic [1:0]    sts, ien;
  logic [PW-1:0] hcnt, vcnt;
  logic [5:0]    sig_q;

  logic [AW-1:0] gen_off;
  logic [3:0]    gen_idx;
  logic          gen_sel, run, last, copy;
  assign gen_off = reg_addr - A_GEN;
  assign gen_idx = gen_off[5:2];
  assign gen_sel = reg_addr >= A_GEN && reg_addr < A_GEN + AW'(4*NREG);
  assign run     = ctrl[2];

  logic [PW-1:0] ha, va, htot, vtot, hss, hse, vbs, vbe, vss, vse, vhs, vhe;
  logic [5:0]    pol;
  assign ha   = wrk[0][PW-1:0];
  assign va   = wrk[0][HI +: PW];
  assign pol  = wrk[3][5:0];
  assign htot = wrk[4][PW-1:0];
  assign vtot = wrk[5][PW-1:0];
  assign hss  = wrk[6][PW-1:0];
  assign hse  = wrk[6][HI +: PW];
  assign vbs  = wrk[7][PW-1:0];
  assign vbe  = wrk[7][HI +: PW];
  assign vss  = wrk[8][PW-1:0];
  assign vse  = wrk[8][HI +: PW];
  assign vhs  = wrk[9][PW-1:0];
  assign vhe  = wrk[9][HI +: PW];

  logic unused_bits;
  assign unused_bits = ^{wrk[1], wrk[2], wrk[0][31:HI+PW], wrk[0][HI-1:PW], wrk[3][31:6],
                         wrk[4][31:PW], wrk[5][31:PW], wrk[6][31:HI+PW], wrk[6][HI-1:PW],
                         wrk[7][31:HI+PW], wrk[7][HI-1:PW], wrk[8][31:HI+PW], wrk[8][HI-1:PW],
                         wrk[9][31:HI+PW], wrk[9][HI-1:PW], gen_off[AW-1:6], gen_off[1:0]};

  logic h_end, v_end;
  assign h_end = hcnt >= htot - PW'(1);
  assign v_end = vcnt >= vtot - PW'(1);
  assign last  = h_end && v_end;
  assign copy  = pend && (!run || last);

  logic hb, vb, hs, vs, av;
  assign hb = hcnt >= ha;
  assign vb = at_or_after(vcnt, hcnt, va, vbs) || !at_or_after(vcnt, hcnt, '0, vbe);
  assign hs = hcnt >= hss && hcnt < hse;
  assign vs = at_or_after(vcnt, hcnt, vss, vhs) && !at_or_after(vcnt, hcnt, vse, vhe);
  assign av = !hb && !vb;

  logic [1:0] ev, clr;
  assign ev  = {run && hcnt == '0 && vcnt == '0, run && vcnt == va && hcnt == vbs};
  assign clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[EV +: 2] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        shd[i] <= '0;
        wrk[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (copy) wrk[i] <= shd[i];
        if (reg_we && gen_sel && gen_idx == 4'(i)) shd[i] <= reg_wdata & wmask(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      pend <= 1'b0;
      ien  <= '0;
      sts  <= '0;
    end else begin
      sts <= (sts & ~clr) | ev;
      if (reg_we && reg_addr == A_IEN) ien <= reg_wdata[EV +: 2];
      if (reg_we && reg_addr == A_CTRL) begin
        ctrl <= {reg_wdata[31:1], 1'b0};
        pend <= reg_wdata[0] | (pend & !copy);
      end else if (copy) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      vcnt  <= '0;
      sig_q <= '1;
    end else begin
      sig_q <= ~({av, av, hs, vs, hb, vb} & {6{run}} ^ pol);
      if (!run) begin
        hcnt <= '0;
        vcnt <= '0;
      end else if (h_end) begin
        hcnt <= '0;
        vcnt <= v_end ? '0 : vcnt + PW'(1);
      end else begin
        hcnt <= hcnt + PW'(1);
      end
    end
  end

  assign {active_chroma_o, active_video_o, hsync_o, vsync_o, hblank_o, vblank_o} = sig_q;
  assign irq_o = |(sts & ien);

  always_comb begin
    reg_rdata = '0;
    if (gen_sel) reg_rdata = shd[gen_idx];
    else if (reg_addr == A_CTRL) reg_rdata = {ctrl[31:1], pend};
    else if (reg_addr == A_STAT) reg_rdata = 32'(sts) << EV;
    else if (reg_addr == A_IEN)  reg_rdata = 32'(ien) << EV;
  end

  // R3
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && htot != '0) |-> hcnt < htot);
  // R3
  vcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && vtot != '0) |-> vcnt < vtot);
  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ({active_chroma_o, active_video_o, hsync_o, vsync_o, hblank_o, vblank_o} == ~$past(pol)));
  // R9
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wrk[4]) |-> $past(pend && (!run || last)));
  // R10
  sticky_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !(reg_we && reg_addr == A_STAT && reg_wdata[EV+1])) |=> sts[1]);
  // R10
  sticky_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !(reg_we && reg_addr == A_STAT && reg_wdata[EV])) |=> sts[0]);
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, reg_we;
  logic [8:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic hsync_o, vsync_o, hblank_o, vblank_o, active_video_o, active_chroma_o, irq_o;

  raster_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o), .vblank_o(vblank_o),
    .active_video_o(active_video_o), .active_chroma_o(active_chroma_o), .irq_o(irq_o));

  int checks = 0, errors = 0;
  bit go = 0;

  logic [31:0] m_sh [10];
  logic [31:0] m_wk [10];
  logic [31:0] m_ctrl, m_sts, m_ien;
  logic m_pend, m_run, m_last, m_copy, exp_irq;
  logic [12:0] mh, mv;
  logic [5:0] exp_o;
  logic [31:0] ev_w;

  function automatic logic [31:0] fmask(input int idx);
    if (idx == 0 || idx >= 6) return 32'h1FFF_1FFF;
    if (idx == 3) return 32'h0000_003F;
    if (idx == 4 || idx == 5) return 32'h0000_1FFF;
    return 32'h0;
  endfunction

  function automatic logic [5:0] model_raw(input logic [12:0] h, v);
    logic [25:0] k;
    logic hb, vb, hs, vs, av;
    k  = {v, h};
    hb = h >= m_wk[0][12:0];
    vb = (k >= {m_wk[0][28:16], m_wk[7][12:0]}) || (k < {13'd0, m_wk[7][28:16]});
    hs = (h >= m_wk[6][12:0]) && (h < m_wk[6][28:16]);
    vs = (k >= {m_wk[8][12:0], m_wk[9][12:0]}) && (k < {m_wk[8][28:16], m_wk[9][28:16]});
    av = !hb && !vb;
    return {av, av, hs, vs, hb, vb};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) begin m_sh[i] = 0; m_wk[i] = 0; end
      m_ctrl = 0; m_sts = 0; m_ien = 0; m_pend = 0; mh = 0; mv = 0;
      exp_o = 6'h3F; exp_irq = 0;
    end else begin
      m_run = m_ctrl[2];
      exp_o = m_run ? ~(model_raw(mh, mv) ^ m_wk[3][5:0]) : ~m_wk[3][5:0];
      ev_w = 0;
      if (m_run && mh == 0 && mv == 0) ev_w[13] = 1;
      if (m_run && mv == m_wk[0][28:16] && mh == m_wk[7][12:0]) ev_w[12] = 1;
      m_last = (mh >= 13'(m_wk[4][12:0] - 13'd1)) && (mv >= 13'(m_wk[5][12:0] - 13'd1));
      m_copy = m_pend && (!m_run || m_last);
      if (!m_run) begin mh = 0; mv = 0; end
      else if (mh >= 13'(m_wk[4][12:0] - 13'd1)) begin
        mh = 0;
        mv = (mv >= 13'(m_wk[5][12:0] - 13'd1)) ? 13'd0 : mv + 13'd1;
      end else mh = mh + 13'd1;
      if (reg_we && reg_addr == 9'h004) m_sts = m_sts & ~(reg_wdata & 32'h3000);
      m_sts = m_sts | ev_w;
      if (m_copy) begin
        for (int i = 0; i < 10; i++) m_wk[i] = m_sh[i];
        m_pend = 0;
      end
      if (reg_we) begin
        if (reg_addr == 9'h000) begin
          m_ctrl = reg_wdata & ~32'h1;
          if (reg_wdata[0]) m_pend = 1;
        end
        if (reg_addr == 9'h00C) m_ien = reg_wdata & 32'h3000;
        if (reg_addr >= 9'h060 && reg_addr < 9'h088)
          m_sh[(reg_addr - 9'h060) >> 2] = reg_wdata & fmask((reg_addr - 9'h060) >> 2);
      end
      exp_irq = |(m_sts & m_ien);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] outs();
    return {active_chroma_o, active_video_o, hsync_o, vsync_o, hblank_o, vblank_o};
  endfunction

  always @(negedge clk) begin
    if (rst_n && go) begin
      chk("R3 R4 R5 R6 R7 timing outputs", {26'd0, outs()}, {26'd0, exp_o});
      chk("R11 irq", {31'd0, irq_o}, {31'd0, exp_irq});
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_random();
    int ht, ha, hs0, hs1, vt, va, vs0, vs1;
    ht = $urandom_range(24, 6); ha = $urandom_range(ht - 1, 1);
    hs0 = $urandom_range(ht - 2, 0); hs1 = $urandom_range(ht - 1, hs0 + 1);
    vt = $urandom_range(10, 4); va = $urandom_range(vt - 1, 1);
    vs0 = $urandom_range(vt - 2, 0); vs1 = $urandom_range(vt - 1, vs0 + 1);
    wr(9'h060, (va << 16) | ha);
    wr(9'h06C, $urandom_range(63, 0));
    wr(9'h070, ht);
    wr(9'h074, vt);
    wr(9'h078, (hs1 << 16) | hs0);
    wr(9'h07C, ($urandom_range(ht - 1, 0) << 16) | $urandom_range(ht - 1, 0));
    wr(9'h080, (vs1 << 16) | vs0);
    wr(9'h084, ($urandom_range(ht - 1, 0) << 16) | $urandom_range(ht - 1, 0));
  endtask

  logic [31:0] rv;
  int err_mark;

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    idle(4);
    rst_n = 1; go = 1;
    #1 chk("R1 outputs after reset", {26'd0, outs()}, 32'h3F);
    chk("R1 irq after reset", {31'd0, irq_o}, 0);
    rd(9'h000, rv); chk("R1 control", rv, 0);
    rd(9'h004, rv); chk("R1 status", rv, 0);

    for (int i = 0; i < 10; i++) begin
      wr(9'(9'h060 + 4 * i), 32'hFFFF_FFFF);
      rd(9'(9'h060 + 4 * i), rv);
      chk("R2 readback mask", rv, fmask(i));
    end

    wr(9'h060, (4 << 16) | 6);
    wr(9'h06C, 32'h3F);
    wr(9'h070, 10);
    wr(9'h074, 6);
    wr(9'h078, (9 << 16) | 7);
    wr(9'h07C, 0);
    wr(9'h080, (5 << 16) | 4);
    wr(9'h084, 0);
    wr(9'h000, 1);
    rd(9'h000, rv); chk("R9 pending reads 0 after stopped commit", rv, 0);
    wr(9'h000, 4);
    idle(130);
    rd(9'h004, rv); chk("R10 both events seen", rv, 32'h3000);
    wr(9'h004, 32'h1000);
    rd(9'h004, rv); chk("R10 clear vblank event", rv, m_sts);
    wr(9'h00C, 32'h2000);
    idle(40);

    err_mark = errors;
    wr(9'h070, 20);
    wr(9'h078, (3 << 16) | 1);
    idle(100);
    rd(9'h070, rv); chk("R2 shadow readback while uncommitted", rv, 20);
    chk("R9 no effect without commit", errors - err_mark, 0);
    wr(9'h000, 5);
    rd(9'h000, rv); chk("R9 pending flag", rv[0], m_pend);
    idle(200);
    rd(9'h000, rv); chk("R9 commit applied", rv, 4);

    wr(9'h000, 0);
    idle(2);
    chk("R8 stopped outputs inactive", {26'd0, outs()}, {26'd0, ~m_wk[3][5:0]});
    wr(9'h000, 4);
    idle(60);

    for (int it = 0; it < 10; it++) begin
      bit stopped;
      stopped = $urandom_range(1, 0);
      if (stopped) wr(9'h000, 0);
      cfg_random();
      wr(9'h00C, $urandom_range(3, 0) << 12);
      if (!stopped) idle($urandom_range(60, 0));
      if (stopped) begin wr(9'h000, 1); wr(9'h000, 4); end
      else wr(9'h000, 5);
      idle($urandom_range(400, 150));
      rd(9'h004, rv); chk("R10 status sticky", rv, m_sts);
      wr(9'h004, $urandom_range(3, 0) << 12);
      rd(9'h004, rv); chk("R10 status after clear", rv, m_sts);
      rd(9'h00C, rv); chk("R11 enable readback", rv, m_ien);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule